// File: doc/BRIEF.md
# Query-Driven Victim Selector for an Inclusive Shared Cache Set

This block picks the way to evict from one 16-way set of an inclusive shared cache when that set takes a miss. A plain eviction of the least recently used line would force a back-invalidate of a line that may still be hot in a private core cache. To avoid that, the selector first asks the core caches whether the oldest candidate is still held there. If the candidate is absent, it becomes the victim. If it is present, the selector promotes it to most recently used and asks about the next-oldest line. A programmable budget limits how many questions one miss may ask.

The selector runs while the memory fetch for the missing line is in flight, so its few round trips stay off the critical path. Any invalid way is used at once and no query is issued. When the budget runs out and every candidate asked about was still resident, the line that is then oldest is evicted anyway, and the result is flagged so that the surrounding logic sends a back-invalidate for it.

The miss request and the query request are valid/ready channels. A transfer happens on a clock edge where both valid and ready are high. A request holds its valid and payload until it is accepted, and the block applies back-pressure on misses by holding `miss_ready` low while a selection is in progress. The presence response, the victim result and the hit hint are single-cycle pulses with no back-pressure.

Top module: `llc_vsel`

## Requirements
- R1: After reset the recency order is way 0 most recent through way 15 oldest, `miss_ready` is 1, and `qry_valid` and `vic_valid` are 0.
- R2: A miss is accepted on an edge where `miss_valid` and `miss_ready` are both 1. `miss_ready` stays 0 from the cycle after acceptance through the cycle in which `vic_valid` is high.
- R3: If `line_valid` (bit n = way n holds a line) sampled at acceptance has any 0 bit, the lowest-numbered invalid way is returned as the victim with `vic_binv` = 0 and no query is issued.
- R4: Otherwise, the first query of a miss carries the way that is oldest in the recency order.
- R5: `qry_valid` and `qry_way` hold steady until `qry_ready` is 1. After a query is accepted, `qry_valid` stays 0 until its response (`rsp_valid` pulse) arrives, so at most one query is outstanding.
- R6: A response with `rsp_present` = 0 makes the queried way the victim, with `vic_binv` = 0.
- R7: A response with `rsp_present` = 1 moves the queried way to most recent. If the budget allows, the next query carries the way that is then oldest.
- R8: The budget is `cfg_qlimit`, sampled at acceptance, and a value of 0 acts as 1. At most that many queries are accepted per miss. If all of them report present, the way that is oldest after the promotions is the victim, with `vic_binv` = 1.
- R9: `vic_valid` is high for exactly one cycle per miss, together with `vic_way`. The victim way then becomes most recent.
- R10: A `hit_valid` pulse while `miss_ready` is 1 moves `hit_way` to most recent. While a miss is in progress, a hit pulse has no effect on the recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request for this set |
| miss_ready | output | 1 | Selector idle and able to take a miss |
| line_valid | input | 16 | Per-way valid bits from the tag array |
| cfg_qlimit | input | 4 | Query budget per miss (0 acts as 1) |
| hit_valid | input | 1 | Hit in this set, pulse |
| hit_way | input | 4 | Way that hit |
| qry_valid | output | 1 | Presence query toward the core caches |
| qry_ready | input | 1 | Core caches accept the query |
| qry_way | output | 4 | Way being queried |
| rsp_valid | input | 1 | Presence response, pulse |
| rsp_present | input | 1 | 1 if any core cache holds the queried line |
| vic_valid | output | 1 | Victim result, one-cycle pulse |
| vic_way | output | 4 | Chosen victim way |
| vic_binv | output | 1 | Victim not confirmed absent; back-invalidate it |

## Verification
The hardest case to reach from the ports is an exhausted budget, where every queried line is still resident and the victim becomes the line that was never asked about. In that case the promotions done during the miss are the only thing that decides which way comes out. To reach it, the bench sets dense presence masks and budgets from 0 up to 15. It adds random query back-pressure, random response delays, and hit pulses injected while a query is waiting, so the recency model has to track every promotion exactly.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK,
    ST_WAIT,
    ST_FINAL,
    ST_DONE
  } vsel_state_e;
endpackage

// File: rtl/vsel_recency.sv
module vsel_recency #(
  parameter int WAYS = 16,
  localparam int WW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [WW-1:0] touch_way,
  output logic [WW-1:0] oldest_way
);
  // rank 0 = most recent, rank WAYS-1 = oldest
  logic [WW-1:0] rank_q [WAYS];
  logic [WW-1:0] touched_rank;

  assign touched_rank = rank_q[touch_way];

  for (genvar g = 0; g < WAYS; g++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_q[g] <= WW'(g);
      end else if (touch) begin
        if (touch_way == WW'(g)) begin
          rank_q[g] <= '0;
        end else if (rank_q[g] < touched_rank) begin
          rank_q[g] <= rank_q[g] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (rank_q[i] == WW'(WAYS - 1)) oldest_way = WW'(i);
    end
  end
endmodule

// File: rtl/vsel_free_find.sv
module vsel_free_find #(
  parameter int WAYS = 16,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] line_valid,
  output logic            any_free,
  output logic [WW-1:0]   free_way
);
  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!line_valid[i]) begin
        any_free = 1'b1;
        free_way = WW'(i);
      end
    end
  end
endmodule

// File: rtl/vsel_ctrl.sv
module vsel_ctrl
  import vsel_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int LIM_W = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic             any_free,
  input  logic [WW-1:0]    free_way,
  input  logic [LIM_W-1:0] cfg_qlimit,
  input  logic             hit_valid,
  input  logic [WW-1:0]    hit_way,
  output logic             qry_valid,
  input  logic             qry_ready,
  output logic [WW-1:0]    qry_way,
  input  logic             rsp_valid,
  input  logic             rsp_present,
  output logic             vic_valid,
  output logic [WW-1:0]    vic_way,
  output logic             vic_binv,
  input  logic [WW-1:0]    oldest_way,
  output logic             touch,
  output logic [WW-1:0]    touch_way
);
  vsel_state_e      state_q;
  logic [WW-1:0]    cand_q;
  logic [WW-1:0]    pick_q;
  logic             binv_q;
  logic [LIM_W-1:0] used_q;
  logic [LIM_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cand_q  <= '0;
      pick_q  <= '0;
      binv_q  <= 1'b0;
      used_q  <= '0;
      lim_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (miss_valid) begin
            lim_q  <= (cfg_qlimit == '0) ? LIM_W'(1) : cfg_qlimit;
            used_q <= '0;
            if (any_free) begin
              pick_q  <= free_way;
              binv_q  <= 1'b0;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_ASK;
            end
          end
        end
        ST_ASK: begin
          if (qry_ready) begin
            cand_q  <= oldest_way;
            used_q  <= used_q + 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!rsp_present) begin
              pick_q  <= cand_q;
              binv_q  <= 1'b0;
              state_q <= ST_DONE;
            end else if (used_q == lim_q) begin
              state_q <= ST_FINAL;
            end else begin
              state_q <= ST_ASK;
            end
          end
        end
        ST_FINAL: begin
          pick_q  <= oldest_way;
          binv_q  <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    touch     = 1'b0;
    touch_way = hit_way;
    unique case (state_q)
      ST_IDLE: touch = hit_valid;
      ST_WAIT: begin
        touch     = rsp_valid && rsp_present;
        touch_way = cand_q;
      end
      ST_DONE: begin
        touch     = 1'b1;
        touch_way = pick_q;
      end
      default: touch = 1'b0;
    endcase
  end

  assign miss_ready = (state_q == ST_IDLE);
  assign qry_valid  = (state_q == ST_ASK);
  assign qry_way    = oldest_way;
  assign vic_valid  = (state_q == ST_DONE);
  assign vic_way    = pick_q;
  assign vic_binv   = (state_q == ST_DONE) && binv_q;
endmodule

// File: rtl/llc_vsel.sv
module llc_vsel #(
  parameter int WAYS  = 16,
  parameter int LIM_W = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [WAYS-1:0]  line_valid,
  input  logic [LIM_W-1:0] cfg_qlimit,
  input  logic             hit_valid,
  input  logic [WW-1:0]    hit_way,
  output logic             qry_valid,
  input  logic             qry_ready,
  output logic [WW-1:0]    qry_way,
  input  logic             rsp_valid,
  input  logic             rsp_present,
  output logic             vic_valid,
  output logic [WW-1:0]    vic_way,
  output logic             vic_binv
);
  logic          any_free;
  logic [WW-1:0] free_way;
  logic [WW-1:0] oldest_way;
  logic          touch;
  logic [WW-1:0] touch_way;

  vsel_free_find #(.WAYS(WAYS)) u_free (
    .line_valid (line_valid),
    .any_free   (any_free),
    .free_way   (free_way)
  );

  vsel_recency #(.WAYS(WAYS)) u_rank (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (touch),
    .touch_way  (touch_way),
    .oldest_way (oldest_way)
  );

  vsel_ctrl #(.WAYS(WAYS), .LIM_W(LIM_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .miss_ready  (miss_ready),
    .any_free    (any_free),
    .free_way    (free_way),
    .cfg_qlimit  (cfg_qlimit),
    .hit_valid   (hit_valid),
    .hit_way     (hit_way),
    .qry_valid   (qry_valid),
    .qry_ready   (qry_ready),
    .qry_way     (qry_way),
    .rsp_valid   (rsp_valid),
    .rsp_present (rsp_present),
    .vic_valid   (vic_valid),
    .vic_way     (vic_way),
    .vic_binv    (vic_binv),
    .oldest_way  (oldest_way),
    .touch       (touch),
    .touch_way   (touch_way)
  );
endmodule

// File: rtl/llc_vsel_checker.sv
module llc_vsel_checker #(
  parameter int WAYS  = 16,
  parameter int LIM_W = 4,
  localparam int WW = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic [WAYS-1:0]  line_valid,
  input logic [LIM_W-1:0] cfg_qlimit,
  input logic             qry_valid,
  input logic             qry_ready,
  input logic [WW-1:0]    qry_way,
  input logic             vic_valid,
  input logic             vic_binv
);
  logic [LIM_W-1:0] seen_q;
  logic [LIM_W-1:0] budget_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q   <= '0;
      budget_q <= '0;
    end else if (miss_valid && miss_ready) begin
      seen_q   <= '0;
      budget_q <= (cfg_qlimit == '0) ? LIM_W'(1) : cfg_qlimit;
    end else if (qry_valid && qry_ready) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  assert_free_no_query_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && !(&line_valid)) |=> (vic_valid && !vic_binv && !qry_valid));

  assert_query_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && !qry_ready) |=> (qry_valid && $stable(qry_way)));

  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_ready) |=> !qry_valid);

  assert_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_ready) |-> (seen_q < budget_q));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |=> !vic_valid);
endmodule

bind llc_vsel llc_vsel_checker #(.WAYS(WAYS), .LIM_W(LIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .line_valid (line_valid),
  .cfg_qlimit (cfg_qlimit),
  .qry_valid  (qry_valid),
  .qry_ready  (qry_ready),
  .qry_way    (qry_way),
  .vic_valid  (vic_valid),
  .vic_binv   (vic_binv)
);

// File: tb/llc_vsel_tb_top.sv
module llc_vsel_tb_top;
  localparam int WAYS = 16;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic miss_ready;
  logic [WAYS-1:0] line_valid = '1;
  logic [3:0] cfg_qlimit = 4'd2;
  logic hit_valid = 1'b0;
  logic [WW-1:0] hit_way = '0;
  logic qry_valid;
  logic qry_ready = 1'b0;
  logic [WW-1:0] qry_way;
  logic rsp_valid = 1'b0;
  logic rsp_present = 1'b0;
  logic vic_valid;
  logic [WW-1:0] vic_way;
  logic vic_binv;

  int checks = 0;
  int errors = 0;
  int rank_m [WAYS];

  always #5 clk = ~clk;

  llc_vsel dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .line_valid(line_valid), .cfg_qlimit(cfg_qlimit), .hit_valid(hit_valid),
    .hit_way(hit_way), .qry_valid(qry_valid), .qry_ready(qry_ready),
    .qry_way(qry_way), .rsp_valid(rsp_valid), .rsp_present(rsp_present),
    .vic_valid(vic_valid), .vic_way(vic_way), .vic_binv(vic_binv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int oldest_m();
    int w = 0;
    for (int i = 0; i < WAYS; i++) if (rank_m[i] == WAYS - 1) w = i;
    return w;
  endfunction

  function automatic void promote_m(input int w);
    int r = rank_m[w];
    for (int i = 0; i < WAYS; i++) if (rank_m[i] < r) rank_m[i]++;
    rank_m[w] = 0;
  endfunction

  function automatic int lowest_free(input logic [WAYS-1:0] lv);
    for (int i = 0; i < WAYS; i++) if (!lv[i]) return i;
    return -1;
  endfunction

  task automatic hit_idle(input int w);
    @(negedge clk);
    hit_valid = 1'b1;
    hit_way = WW'(w);
    promote_m(w); // R10 hit while idle
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic run_miss(input logic [WAYS-1:0] lv, input logic [WAYS-1:0] pres,
                          input int lim, input bit hit_mid, input int hw);
    int elim, nq, pend, dly, cand, freew, cyc, expw;
    bit last_abs, done, hit_done, expb;
    elim = (lim == 0) ? 1 : lim;
    freew = lowest_free(lv);
    nq = 0; pend = 0; dly = 0; cand = 0; cyc = 0;
    last_abs = 1'b0; done = 1'b0; hit_done = 1'b0;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R2 ready before miss", int'(miss_ready), 1);
    miss_valid = 1'b1;
    line_valid = lv;
    cfg_qlimit = 4'(lim);
    @(negedge clk);
    miss_valid = 1'b0;
    chk(miss_ready == 1'b0, "R2 busy after accept", int'(miss_ready), 0);
    while (!done && cyc < 300) begin
      cyc++;
      rsp_valid = 1'b0;
      hit_valid = 1'b0;
      if (vic_valid) begin
        if (freew >= 0) begin
          expw = freew; expb = 1'b0;
          chk(nq == 0, "R3 no query on free way", nq, 0);
        end else if (last_abs) begin
          expw = cand; expb = 1'b0; // R6
        end else begin
          expw = oldest_m(); expb = 1'b1; // R8
          chk(nq == elim, "R8 queries used", nq, elim);
        end
        chk(int'(vic_way) == expw, "R3/R6/R8 victim way", int'(vic_way), expw);
        chk(vic_binv == expb, "R6/R8 back-invalidate flag", int'(vic_binv), int'(expb));
        promote_m(expw); // R9 victim becomes most recent
        done = 1'b1;
        @(negedge clk);
        chk(vic_valid == 1'b0, "R9 single pulse", int'(vic_valid), 0);
        chk(miss_ready == 1'b1, "R2 ready after victim", int'(miss_ready), 1);
      end else if (qry_ready) begin
        qry_ready = 1'b0;
        chk(qry_valid == 1'b0, "R5 one outstanding", int'(qry_valid), 0);
        pend = 2;
        dly = int'($urandom % 4);
      end else if (pend == 2) begin
        chk(qry_valid == 1'b0, "R5 no query while waiting", int'(qry_valid), 0);
        if (hit_mid && !hit_done) begin
          hit_valid = 1'b1; // R10 ignored during miss, model untouched
          hit_way = WW'(hw);
          hit_done = 1'b1;
        end
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_present = pres[cand];
          if (pres[cand]) promote_m(cand); // R7
          else last_abs = 1'b1;
          pend = 0;
        end else begin
          dly--;
        end
      end else if (qry_valid) begin
        chk(int'(qry_way) == oldest_m(), "R4/R7 query way is oldest", int'(qry_way), oldest_m());
        chk(nq < elim, "R8 budget", nq, elim);
        chk(freew < 0, "R3 query with free way", freew, -1);
        cand = int'(qry_way);
        if ($urandom % 3 != 0) begin
          qry_ready = 1'b1;
          nq++;
        end
      end
      if (!done) @(negedge clk);
    end
    chk(done, "R9 victim produced", int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WAYS-1:0] lv, pres;
    void'($urandom(32'd2718));
    for (int i = 0; i < WAYS; i++) rank_m[i] = i; // R1
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R1 reset ready", int'(miss_ready), 1);
    chk(qry_valid == 1'b0, "R1 reset query", int'(qry_valid), 0);
    chk(vic_valid == 1'b0, "R1 reset victim", int'(vic_valid), 0);

    // R1: oldest after reset is way 15, absent -> victim 15
    run_miss('1, '0, 2, 1'b0, 0);
    // R3: lowest invalid way wins
    run_miss(~(16'h0220), '1, 2, 1'b0, 0);
    // R8: all present, budget 2
    run_miss('1, '1, 2, 1'b0, 0);
    // R8: budget 0 acts as 1
    run_miss('1, '1, 0, 1'b0, 0);
    // R7/R6: oldest present, next absent
    run_miss('1, 16'(1 << oldest_m()), 3, 1'b0, 0);
    // R10: hit while idle promotes the oldest
    hit_idle(oldest_m());
    run_miss('1, '0, 2, 1'b0, 0);
    // R10: hit during a miss is ignored
    run_miss('1, '1, 3, 1'b1, oldest_m());
    // R8: large budget with all present
    run_miss('1, '1, 15, 1'b0, 0);

    for (int n = 0; n < 300; n++) begin
      lv = ($urandom % 5 == 0) ? WAYS'($urandom) | WAYS'($urandom) : '1;
      pres = WAYS'($urandom) | WAYS'($urandom);
      if ($urandom % 4 == 0) pres = '1;
      if ($urandom % 6 == 0) hit_idle(int'($urandom % WAYS));
      run_miss(lv, pres, int'($urandom % 6), ($urandom % 3 == 0), int'($urandom % WAYS));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule